// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is the slave end of a two-wire serial control port. It gives a host access to a small bank of 8-bit configuration registers. SCL and SDA arrive as plain inputs. The block pulls SDA low through an output-enable and never drives SCL. Both lines are oversampled by the system clock through a synchronizer and a glitch filter. Start and stop conditions are recognised as SDA edges while SCL is high.

The device answers a 7-bit address. Its five upper bits are a parameter and its two lower bits come from strap pins. After a write address, the first byte is a pointer byte: its top bit turns on auto-increment and its low bits pick a register. Data bytes that follow go into the pointed register.

A read transaction has no pointer phase. It returns data from wherever the last write left the pointer. A write made of only an address and a pointer byte, closed by a stop, is therefore how a host aims a later read. One register slot mirrors a read-only status input. One bit of the control register holds the datapath in soft reset while it is clear; the port itself keeps working in that state.

Top module: `twi_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its seven upper bits, sent MSB first, equal {ADDR_HI, strap_i[1], strap_i[0]} (default ADDR_HI = 5'b00100). The last bit selects direction: 0 is write, 1 is read. On any other address it leaves SDA released and takes no part in the bus until the next start.
- R2: After an acknowledged write address, the next byte is acknowledged and loads the pointer. Bit 7 of that byte enables auto-increment, and bits [PTR_W-1:0] select the register (PTR_W = log2 NUM_REGS).
- R3: Each complete write data byte is acknowledged and stored in the pointed register. With auto-increment on, the pointer then advances by one and wraps from NUM_REGS-1 to 0. With it off, the pointer stays put and every byte lands in the same register.
- R4: A read returns data starting at the current pointer. This includes a pointer set by a write that ended with a stop right after the pointer byte.
- R5: During a read, each byte answered by a master ACK is followed by the next byte. The pointer advances first if auto-increment is on, wrapping from NUM_REGS-1 to 0. A master NACK ends the burst and leaves the pointer unchanged.
- R6: Register STAT_IDX (default NUM_REGS-1) reads back status_i. Writes to it are acknowledged and have no effect.
- R7: While rst_n is low, every writable register is 0 and SDA is released. Bus traffic in that time is not acknowledged and changes nothing.
- R8: dp_rst_o is 1 while bit RUN_BIT (default 0) of register CTRL_IDX (default 0) is 0, and 0 once that bit is written to 1.
- R9: A stop or a repeated start in the middle of a byte abandons that byte without writing any register. A repeated start begins a new address phase.
- R10: The slave changes its SDA output-enable only while SCL is low. It releases SDA after each acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| strap_i | input | 2 | Strap pins giving the two low address bits |
| status_i | input | 8 | Value presented by the read-only status register |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |
| regs_o | output | NUM_REGS*8 | All register slots, slot i at bits [8i+7:8i] |
| dp_rst_o | output | 1 | Soft reset for the datapath, high while the run bit is clear |

## Verification
The hardest case to reach from the pins is a byte cut short at an arbitrary bit by a stop or repeated start. A correct master never does this. The bench therefore has bit-level tasks that clock out only part of a byte and then issue the condition. It then confirms through regs_o that nothing was stored and that a fresh address phase still works. The other case that takes deliberate setup is a pointer that wraps during a read burst right after an aborted write. Directed sequences place the pointer one or two slots below the top. Random transactions with random pointers, burst lengths and auto-increment settings then cross the wrap point and the status slot many more times.

// File: rtl/twi_regbank_pkg.sv
package twi_regbank_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RLOAD,
      ST_RDATA,
      ST_RDATA_ACK
   } twi_state_e;

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
)(
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   generate
      if (FILT_LEN <= 1) begin : g_direct
         assign line_o = sync_q[SYNC_STAGES-1];
      end else begin : g_count
         localparam int CW = $clog2(FILT_LEN + 1);
         localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN - 1);
         logic [CW-1:0] run_q;
         logic          filt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q  <= '0;
               filt_q <= 1'b1;
            end else if (sync_q[SYNC_STAGES-1] == filt_q) begin
               run_q  <= '0;
            end else if (run_q == LIMIT) begin
               run_q  <= '0;
               filt_q <= sync_q[SYNC_STAGES-1];
            end else begin
               run_q  <= run_q + 1'b1;
            end
         end

         assign line_o = filt_q;
      end
   endgenerate

endmodule

// File: rtl/twi_reg_file.sv
module twi_reg_file #(
   parameter int NUM_REGS = 8,
   parameter int PTR_W    = 3,
   parameter int STAT_IDX = 7
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PTR_W-1:0]      wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [PTR_W-1:0]      rd_addr,
   output logic [7:0]            rd_data,
   input  logic [7:0]            status_i,
   output logic [NUM_REGS*8-1:0] regs_o
);

   logic [7:0] slot [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
         if (g == STAT_IDX) begin : g_status
            assign slot[g] = status_i;
         end else begin : g_store
            logic [7:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  val_q <= 8'h00;
               else if (wr_en && (wr_addr == PTR_W'(g)))
                  val_q <= wr_data;
            end
            assign slot[g] = val_q;
         end
         assign regs_o[g*8 +: 8] = slot[g];
      end
   endgenerate

   assign rd_data = slot[rd_addr];

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
   import twi_regbank_pkg::*;
#(
   parameter int         PTR_W   = 3,
   parameter logic [4:0] ADDR_HI = 5'b00100
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_f,
   input  logic             sda_f,
   input  logic [1:0]       strap_i,
   input  logic [7:0]       rd_data,
   output logic [PTR_W-1:0] ptr_o,
   output logic             sda_oe_o,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_addr_o,
   output logic [7:0]       wr_data_o,
   output twi_state_e       state_o
);

   localparam logic [3:0] RX_DONE = 4'(BYTE_W);
   localparam logic [3:0] TX_LAST = 4'(BYTE_W - 1);

   twi_state_e       state;
   logic [3:0]       cnt;
   logic [7:0]       shreg;
   logic [7:0]       txreg;
   logic [PTR_W-1:0] ptr;
   logic             auto_inc;
   logic             rnw;
   logic             mack;
   logic             sda_oe;
   logic             wr_en;
   logic [PTR_W-1:0] wr_addr;
   logic [7:0]       wr_data;
   logic             scl_q, sda_q;

   logic scl_rise, scl_fall, start_ev, stop_ev, rx_state, addr_hit;
   logic [PTR_W-1:0] ptr_step;

   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
   assign rx_state = state inside {ST_ADDR, ST_PTR, ST_WDATA};
   assign addr_hit = (shreg[7:1] == {ADDR_HI, strap_i});
   assign ptr_step = ptr + PTR_W'(auto_inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         txreg    <= '0;
         ptr      <= '0;
         auto_inc <= 1'b0;
         rnw      <= 1'b0;
         mack     <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
         wr_en <= 1'b0;
         if (start_ev) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_ev) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            if (scl_rise && rx_state) begin
               shreg <= {shreg[6:0], sda_f};
               cnt   <= cnt + 4'd1;
            end
            unique case (state)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_fall && cnt == RX_DONE) begin
                     if (addr_hit) begin
                        state  <= ST_ADDR_ACK;
                        rnw    <= shreg[0];
                        sda_oe <= 1'b1;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= rnw ? ST_RLOAD : ST_PTR;
                  end
               end
               ST_PTR: begin
                  if (scl_fall && cnt == RX_DONE) begin
                     ptr      <= shreg[PTR_W-1:0];
                     auto_inc <= shreg[7];
                     sda_oe   <= 1'b1;
                     state    <= ST_PTR_ACK;
                  end
               end
               ST_PTR_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WDATA;
                  end
               end
               ST_WDATA: begin
                  if (scl_fall && cnt == RX_DONE) begin
                     wr_en   <= 1'b1;
                     wr_addr <= ptr;
                     wr_data <= shreg;
                     ptr     <= ptr_step;
                     sda_oe  <= 1'b1;
                     state   <= ST_WDATA_ACK;
                  end
               end
               ST_RLOAD: begin
                  txreg  <= rd_data;
                  sda_oe <= ~rd_data[7];
                  cnt    <= '0;
                  state  <= ST_RDATA;
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (cnt == TX_LAST) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RDATA_ACK;
                     end else begin
                        cnt    <= cnt + 4'd1;
                        txreg  <= {txreg[6:0], 1'b0};
                        sda_oe <= ~txreg[6];
                     end
                  end
               end
               ST_RDATA_ACK: begin
                  if (scl_rise) mack <= ~sda_f;
                  if (scl_fall) begin
                     if (mack) begin
                        ptr   <= ptr_step;
                        state <= ST_RLOAD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign ptr_o     = ptr;
   assign sda_oe_o  = sda_oe;
   assign wr_en_o   = wr_en;
   assign wr_addr_o = wr_addr;
   assign wr_data_o = wr_data;
   assign state_o   = state;

endmodule

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave
   import twi_regbank_pkg::*;
#(
   parameter int         NUM_REGS    = 8,
   parameter int         STAT_IDX    = NUM_REGS - 1,
   parameter int         CTRL_IDX    = 0,
   parameter int         RUN_BIT     = 0,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3,
   parameter logic [4:0] ADDR_HI     = 5'b00100
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic [1:0]            strap_i,
   input  logic [7:0]            status_i,
   output logic                  sda_oe_o,
   output logic [NUM_REGS*8-1:0] regs_o,
   output logic                  dp_rst_o
);

   localparam int PTR_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > 128 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("NUM_REGS must be a power of two from 2 to 128");
   end
   if (STAT_IDX < 0 || STAT_IDX >= NUM_REGS || CTRL_IDX < 0 || CTRL_IDX >= NUM_REGS || CTRL_IDX == STAT_IDX) begin : g_bad_idx
      $error("STAT_IDX and CTRL_IDX must be distinct slots of the bank");
   end
   if (RUN_BIT < 0 || RUN_BIT >= BYTE_W) begin : g_bad_bit
      $error("RUN_BIT must lie inside a byte");
   end
   if (SYNC_STAGES < 2 || FILT_LEN < 1) begin : g_bad_filt
      $error("need at least two synchronizer stages and a filter length of one");
   end

   logic [1:0]       lines_raw;
   logic [1:0]       lines_f;
   logic             scl_f, sda_f;
   logic             wr_en;
   logic [PTR_W-1:0] wr_addr;
   logic [7:0]       wr_data;
   logic [PTR_W-1:0] ptr;
   logic [7:0]       rd_data;
   twi_state_e       fsm_state;

   assign lines_raw = {scl_i, sda_i};

   generate
      for (genvar l = 0; l < 2; l++) begin : g_line
         twi_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (lines_raw[l]),
            .line_o (lines_f[l])
         );
      end
   endgenerate

   assign scl_f = lines_f[1];
   assign sda_f = lines_f[0];

   twi_slave_fsm #(
      .PTR_W   (PTR_W),
      .ADDR_HI (ADDR_HI)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (scl_f),
      .sda_f     (sda_f),
      .strap_i   (strap_i),
      .rd_data   (rd_data),
      .ptr_o     (ptr),
      .sda_oe_o  (sda_oe_o),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .state_o   (fsm_state)
   );

   twi_reg_file #(
      .NUM_REGS (NUM_REGS),
      .PTR_W    (PTR_W),
      .STAT_IDX (STAT_IDX)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (ptr),
      .rd_data  (rd_data),
      .status_i (status_i),
      .regs_o   (regs_o)
   );

   assign dp_rst_o = ~regs_o[CTRL_IDX*BYTE_W + RUN_BIT];

endmodule

// File: rtl/twi_regbank_checks.sv
module twi_regbank_checks
   import twi_regbank_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int STAT_IDX = NUM_REGS - 1
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_f,
   input logic                  sda_oe_o,
   input logic                  wr_en,
   input twi_state_e            fsm_state,
   input logic [NUM_REGS*8-1:0] regs_o,
   input logic                  dp_rst_o
);

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (fsm_state == ST_IDLE) |-> !sda_oe_o); // R1

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe_o) |-> !scl_f); // R10

   AST_WHOLE_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (fsm_state == ST_WDATA_ACK)); // R9

   AST_RUN_BIT_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(dp_rst_o) |-> $past(wr_en)); // R8

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_hold
         if (g != STAT_IDX) begin : g_chk
            AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(regs_o[g*8 +: 8])); // R3
         end
      end
   endgenerate

endmodule

bind twi_regbank_slave twi_regbank_checks #(
   .NUM_REGS (NUM_REGS),
   .STAT_IDX (STAT_IDX)
) u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_f     (scl_f),
   .sda_oe_o  (sda_oe_o),
   .wr_en     (wr_en),
   .fsm_state (fsm_state),
   .regs_o    (regs_o),
   .dp_rst_o  (dp_rst_o)
);

// File: tb/twi_regbank_slave_test.sv
module twi_regbank_slave_test;

   localparam int NR = 8;
   localparam int ST = NR - 1;
   localparam int Q  = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic           rst_n  = 1'b0;
   logic           m_scl  = 1'b1;
   logic           m_sda  = 1'b1;
   logic [1:0]     strap  = 2'b10;
   logic [7:0]     status = 8'hA5;
   logic           sda_oe;
   logic [NR*8-1:0] regs;
   logic           dp_rst;
   logic           sda_line;

   assign sda_line = m_sda & ~sda_oe;

   twi_regbank_slave uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (m_scl),
      .sda_i    (sda_line),
      .strap_i  (strap),
      .status_i (status),
      .sda_oe_o (sda_oe),
      .regs_o   (regs),
      .dp_rst_o (dp_rst)
   );

   int tests = 0;
   int fails = 0;
   int viol  = 0;
   bit done  = 1'b0;
   logic prev_oe = 1'b0;

   logic [7:0] mreg [NR];
   int         mptr  = 0;
   bit         mauto = 1'b0;
   logic [7:0] wbuf [8];

   // R10 monitor: SDA enable may only move while SCL is low
   always @(negedge clk) begin
      if (rst_n && (sda_oe !== prev_oe) && m_scl) viol++;
      prev_oe = sda_oe;
   end

   function automatic logic [7:0] exp_val(input int i);
      return (i == ST) ? status : mreg[i];
   endfunction

   function automatic logic [7:0] dev_byte(input bit rd);
      return {5'b00100, strap, rd};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_regs(input string tag);
      for (int i = 0; i < NR; i++)
         chk(regs[i*8 +: 8] == exp_val(i), tag, int'(regs[i*8 +: 8]), int'(exp_val(i)));
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic send_bit(input bit b, output bit s);
      m_sda = b;  wait_q();
      m_scl = 1'b1; wait_q();
      s = sda_line; wait_q();
      m_scl = 1'b0; wait_q();
   endtask

   task automatic start_c();
      m_sda = 1'b1; wait_q();
      m_scl = 1'b1; wait_q();
      m_sda = 1'b0; wait_q();
      m_scl = 1'b0; wait_q();
   endtask

   task automatic stop_c();
      m_sda = 1'b0; wait_q();
      m_scl = 1'b1; wait_q();
      m_sda = 1'b1; wait_q();
   endtask

   task automatic wr_byte(input logic [7:0] d, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) send_bit(d[i], s);
      send_bit(1'b1, s);
      ack = !s;
   endtask

   task automatic rd_byte(input bit give_ack, output logic [7:0] d);
      bit s;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         send_bit(1'b1, s);
         d = {d[6:0], s};
      end
      send_bit(!give_ack, s);
   endtask

   task automatic addr_ptr(input logic [7:0] pb, input string tag);
      bit a;
      start_c();
      wr_byte(dev_byte(1'b0), a);
      chk(a, {tag, " R1 address ack"}, a, 1);
      wr_byte(pb, a);
      chk(a, {tag, " R2 pointer ack"}, a, 1);
      mptr  = int'(pb[6:0]) % NR;
      mauto = pb[7];
   endtask

   task automatic do_write(input logic [7:0] pb, input int n, input string tag);
      bit a;
      addr_ptr(pb, tag);
      for (int k = 0; k < n; k++) begin
         wr_byte(wbuf[k], a);
         chk(a, {tag, " R3 data ack"}, a, 1);
         if (mptr != ST) mreg[mptr] = wbuf[k];
         if (mauto) mptr = (mptr + 1) % NR;
      end
      stop_c();
      wait_q();
   endtask

   task automatic set_ptr(input logic [7:0] pb, input string tag);
      addr_ptr(pb, tag);
      stop_c();
   endtask

   task automatic do_read(input int n, input string tag);
      bit a;
      logic [7:0] d;
      logic [7:0] e;
      start_c();
      wr_byte(dev_byte(1'b1), a);
      chk(a, {tag, " R1 read address ack"}, a, 1);
      for (int k = 0; k < n; k++) begin
         e = exp_val(mptr);
         rd_byte(k < n - 1, d);
         chk(d == e, {tag, " R4 R5 read data"}, d, e);
         if (k < n - 1 && mauto) mptr = (mptr + 1) % NR;
      end
      stop_c();
      wait_q();
   endtask

   task automatic run_random();
      int n;
      int idx;
      logic [7:0] pb;
      for (int it = 0; it < 20; it++) begin
         n   = 1 + int'($urandom % 4);
         idx = int'($urandom % NR);
         pb  = 8'(idx);
         pb[7] = ($urandom % 2) == 1;
         if (($urandom % 2) == 0) begin
            for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
            do_write(pb, n, "random write R3");
            chk_regs("random regs R3");
         end else begin
            set_ptr(pb, "random aim R4");
            do_read(n, "random read R5");
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      bit a;
      bit s;
      int seed_r;
      seed_r = $urandom(32'd2024);
      for (int i = 0; i < NR; i++) mreg[i] = 8'h00;

      // R7: reset state
      repeat (10) @(negedge clk);
      chk_regs("R7 reset values");
      chk(dp_rst == 1'b1, "R8 datapath held after reset", dp_rst, 1);
      chk(sda_oe == 1'b0, "R7 SDA released in reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R1: wrong strap bits, then wrong upper bits
      start_c();
      wr_byte({5'b00100, ~strap, 1'b0}, a);
      chk(!a, "R1 wrong strap nack", a, 0);
      wr_byte(8'h02, a);
      chk(!a, "R1 ignored until start", a, 0);
      wr_byte(8'hFF, a);
      stop_c();
      start_c();
      wr_byte({5'b00101, strap, 1'b0}, a);
      chk(!a, "R1 wrong upper bits nack", a, 0);
      stop_c();
      wait_q();
      chk_regs("R1 no write after nack");

      // R3 + R6: auto-increment burst across status slot and wrap
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h30; wbuf[3] = 8'h44;
      do_write(8'h80 | 8'(NR - 2), 4, "R3 wrap burst");
      chk_regs("R3 R6 wrap burst regs");
      chk(dp_rst == 1'b1, "R8 run bit still clear", dp_rst, 1);

      // R3: auto-increment off hits one register
      wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C;
      do_write(8'h03, 3, "R3 fixed pointer");
      chk_regs("R3 fixed pointer regs");

      // R4 + R5: aimed read with wrap, then NACK leaves pointer
      set_ptr(8'h80 | 8'(NR - 2), "R4 aim");
      do_read(4, "R4 R5 wrap read");
      do_read(1, "R5 pointer after nack");
      set_ptr(8'h03, "R4 aim fixed");
      do_read(3, "R5 fixed read");

      // R6: status read and ignored write
      status = 8'h3C;
      set_ptr(8'(ST), "R6 aim");
      do_read(1, "R6 status read");
      wbuf[0] = 8'hFF;
      do_write(8'(ST), 1, "R6 status write");
      chk_regs("R6 status unchanged");

      // R8: run bit controls datapath reset
      wbuf[0] = 8'h01;
      do_write(8'h00, 1, "R8 set run");
      chk(dp_rst == 1'b0, "R8 datapath released", dp_rst, 0);
      wbuf[0] = 8'hFE;
      do_write(8'h00, 1, "R8 clear run");
      chk(dp_rst == 1'b1, "R8 datapath held again", dp_rst, 1);

      // R9: stop mid data byte
      addr_ptr(8'h02, "R9 stop");
      for (int i = 0; i < 5; i++) send_bit(1'b1, s);
      stop_c();
      wait_q();
      chk_regs("R9 partial byte then stop");

      // R9: repeated start mid data byte, then a full write
      addr_ptr(8'h04, "R9 restart");
      for (int i = 0; i < 3; i++) send_bit(1'b1, s);
      start_c();
      wr_byte(dev_byte(1'b0), a);
      chk(a, "R9 address after repeated start", a, 1);
      wr_byte(8'h05, a);
      chk(a, "R9 pointer after repeated start", a, 1);
      wr_byte(8'h99, a);
      chk(a, "R9 data after repeated start", a, 1);
      mreg[5] = 8'h99;
      mptr = 5; mauto = 1'b0;
      stop_c();
      wait_q();
      chk_regs("R9 repeated start regs");

      // random mix
      run_random();

      // R7: hardware reset with traffic during reset
      wbuf[0] = 8'h01;
      do_write(8'h00, 1, "R7 preload");
      rst_n = 1'b0;
      wait_q();
      for (int i = 0; i < NR; i++) mreg[i] = 8'h00;
      mptr = 0; mauto = 1'b0;
      chk_regs("R7 regs cleared");
      chk(dp_rst == 1'b1, "R7 R8 datapath held in reset", dp_rst, 1);
      start_c();
      wr_byte(dev_byte(1'b0), a);
      chk(!a, "R7 no ack in reset", a, 0);
      wr_byte(8'h01, a);
      wr_byte(8'h77, a);
      stop_c();
      rst_n = 1'b1;
      wait_q();
      chk_regs("R7 traffic in reset ignored");

      chk(viol == 0, "R10 SDA moved while SCL high", viol, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule